// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard-control unit for an in-order pipeline with five stages: fetch, decode, execute, memory and writeback. Every cycle it takes the register fields of the instruction in decode, along with the branch outcome from execute. It keeps a small record of the destination index, write enable and load flag for each instruction in the execute, memory and writeback stages. From that record it chooses the bypass source for each of the two execute-stage ALU operands. It also raises a one-cycle interlock when an instruction depends on a load that sits directly ahead of it. When a branch resolves as taken under a predict-not-taken policy, it discards the two wrong-path instructions and redirects fetch to the branch target.

The datapath itself lives outside the block: register file, ALU, memories and the pipeline data registers. The datapath feeds in the decoded fields and obeys the hold, bubble, flush and redirect outputs. The block also tells the decode stage when to take the value being written back rather than the register-file read. This covers a register file that does not write before it reads within a cycle.

Top module: `hzc_top`

## Requirements
- R1: After reset, both execute operand selects read 0 (register file), and pc_hold, fd_hold, de_bubble, fd_flush, pc_redirect and both decode bypass flags are low.
- R2: An execute operand select reads 1 (memory-stage result) when the instruction one ahead is a non-load, writes a register, and has a destination equal to that operand's nonzero source index.
- R3: An execute operand select reads 2 (writeback-stage result) when the instruction two ahead writes a register whose index equals the operand's nonzero source index, and R2 does not apply. This includes loads.
- R4: When both the memory-stage and the writeback-stage instructions match an operand, the select reads 1. The younger result wins.
- R5: Register index 0 is never bypassed, never raises an interlock, and never sets a decode bypass flag.
- R6: When execute holds a load that writes a nonzero register, and decode reads that register on either source, pc_hold, fd_hold and de_bubble are high for exactly one cycle. Two cycles after the stall cycle the dependent operand's select reads 2.
- R7: When a branch resolves as taken, pc_redirect, fd_flush and de_bubble are high in that same cycle and redirect_pc equals the branch target. The instruction then in decode never becomes a bypass source.
- R8: A taken branch takes priority over a load-use interlock in the same cycle: pc_hold and fd_hold stay low.
- R9: A decode bypass flag is high when the writeback-stage instruction writes a nonzero register equal to that decode source index. Both flags are low while pc_redirect is high.
- R10: An instruction that does not write a register, and any inserted bubble, never drives an operand select away from 0.
- R11: A branch that resolves as not taken raises neither pc_redirect nor fd_flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1 | input | REG_W | Decode-stage first source index |
| dec_rs2 | input | REG_W | Decode-stage second source index |
| dec_rd | input | REG_W | Decode-stage destination index |
| dec_wr | input | 1 | Decode-stage instruction writes a register |
| dec_ld | input | 1 | Decode-stage instruction is a load |
| br_resolved | input | 1 | Execute stage holds a branch resolved this cycle |
| br_taken | input | 1 | The resolved branch is taken |
| br_target | input | PC_W | Target address of the resolved branch |
| ex_sel_a | output | 2 | First ALU operand source: 0 register file, 1 memory stage, 2 writeback stage |
| ex_sel_b | output | 2 | Second ALU operand source, same encoding |
| dec_wb_fwd_a | output | 1 | Decode first source takes the writeback value |
| dec_wb_fwd_b | output | 1 | Decode second source takes the writeback value |
| pc_hold | output | 1 | Keep the program counter |
| fd_hold | output | 1 | Keep the fetch/decode register |
| de_bubble | output | 1 | Load a bubble into the decode/execute register |
| fd_flush | output | 1 | Clear the fetch/decode register |
| pc_redirect | output | 1 | Load the program counter from redirect_pc |
| redirect_pc | output | PC_W | Fetch redirect address |

## Verification
The bench builds the block with REG_W = 3, which leaves eight registers, and PC_W = 16. With only eight registers, every pairing of producer destination, producer write enable and consumer source index can be swept in full. The sweeps run across both bypass distances, the load-use case and the decode-stage path. Each pairing includes index 0 and the case where both stages match at once. The branch cases are layered on top of a live load-use dependency, so that the flush-over-stall priority and the discarding of the wrong-path instruction can be seen at the operand selects.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int NUM_OPND = 2;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } opnd_src_e;

    // younger (memory stage) result wins over writeback
    function automatic opnd_src_e pick_src(input logic mem_hit, input logic wb_hit);
        if (mem_hit)     return SRC_MEM;
        else if (wb_hit) return SRC_WB;
        else             return SRC_RF;
    endfunction

    function automatic logic idx_hit(input logic wr, input logic [15:0] prod,
                                     input logic [15:0] cons);
        return wr && (prod != 16'd0) && (prod == cons);
    endfunction

endpackage

// File: rtl/hzc_stage_regs.sv
module hzc_stage_regs
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               bubble,
    input  logic [NUM_OPND-1:0][REG_W-1:0]     dec_rs,
    input  logic [REG_W-1:0]                   dec_rd,
    input  logic                               dec_wr,
    input  logic                               dec_ld,
    output logic [NUM_OPND-1:0][REG_W-1:0]     ex_rs,
    output logic [REG_W-1:0]                   ex_rd,
    output logic                               ex_wr,
    output logic                               ex_ld,
    output logic [REG_W-1:0]                   mem_rd,
    output logic                               mem_wr,
    output logic                               mem_ld,
    output logic [REG_W-1:0]                   wb_rd,
    output logic                               wb_wr
);

    typedef struct packed {
        logic                           wr;
        logic                           ld;
        logic [REG_W-1:0]               rd;
        logic [NUM_OPND-1:0][REG_W-1:0] rs;
    } ex_slot_t;

    typedef struct packed {
        logic             wr;
        logic             ld;
        logic [REG_W-1:0] rd;
    } mem_slot_t;

    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] rd;
    } wb_slot_t;

    ex_slot_t  dec_slot, ex_q;
    mem_slot_t mem_q;
    wb_slot_t  wb_q;

    always_comb begin
        dec_slot.wr = dec_wr;
        dec_slot.ld = dec_ld;
        dec_slot.rd = dec_rd;
        dec_slot.rs = dec_rs;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
        end else begin
            ex_q     <= bubble ? '0 : dec_slot;
            mem_q.wr <= ex_q.wr;
            mem_q.ld <= ex_q.ld;
            mem_q.rd <= ex_q.rd;
            wb_q.wr  <= mem_q.wr;
            wb_q.rd  <= mem_q.rd;
        end
    end

    assign ex_rs  = ex_q.rs;
    assign ex_rd  = ex_q.rd;
    assign ex_wr  = ex_q.wr;
    assign ex_ld  = ex_q.ld;
    assign mem_rd = mem_q.rd;
    assign mem_wr = mem_q.wr;
    assign mem_ld = mem_q.ld;
    assign wb_rd  = wb_q.rd;
    assign wb_wr  = wb_q.wr;

endmodule

// File: rtl/hzc_bypass.sv
module hzc_bypass
    import hzc_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [NUM_OPND-1:0][REG_W-1:0] ex_rs,
    input  logic [NUM_OPND-1:0][REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0]               mem_rd,
    input  logic                           mem_wr,
    input  logic                           mem_ld,
    input  logic [REG_W-1:0]               wb_rd,
    input  logic                           wb_wr,
    input  logic                           kill,
    output logic [NUM_OPND-1:0][1:0]       ex_src,
    output logic [NUM_OPND-1:0]            dec_fwd
);

    localparam int PAD = 16 - REG_W;

    // a load in the memory stage has no data yet; its consumer waits a cycle
    logic mem_prod;
    assign mem_prod = mem_wr && !mem_ld;

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
        logic mem_hit, wb_hit, dec_hit;
        assign mem_hit = idx_hit(mem_prod, {{PAD{1'b0}}, mem_rd}, {{PAD{1'b0}}, ex_rs[i]});
        assign wb_hit  = idx_hit(wb_wr,    {{PAD{1'b0}}, wb_rd},  {{PAD{1'b0}}, ex_rs[i]});
        assign dec_hit = idx_hit(wb_wr,    {{PAD{1'b0}}, wb_rd},  {{PAD{1'b0}}, dec_rs[i]});
        assign ex_src[i]  = pick_src(mem_hit, wb_hit);
        assign dec_fwd[i] = dec_hit && !kill;
    end

endmodule

// File: rtl/hzc_interlock.sv
module hzc_interlock
    import hzc_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int PC_W  = 32
) (
    input  logic [NUM_OPND-1:0][REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0]               ex_rd,
    input  logic                           ex_wr,
    input  logic                           ex_ld,
    input  logic                           br_resolved,
    input  logic                           br_taken,
    input  logic [PC_W-1:0]                br_target,
    output logic                           stall,
    output logic                           kill,
    output logic [PC_W-1:0]                target
);

    localparam int PAD = 16 - REG_W;

    logic [NUM_OPND-1:0] use_hit;
    logic                load_use;

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_use
        assign use_hit[i] = idx_hit(ex_wr && ex_ld, {{PAD{1'b0}}, ex_rd},
                                    {{PAD{1'b0}}, dec_rs[i]});
    end

    assign load_use = |use_hit;
    assign kill     = br_resolved && br_taken;
    assign stall    = load_use && !kill;
    assign target   = br_target;

endmodule

// File: rtl/hzc_top.sv
module hzc_top
    import hzc_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] dec_rs1,
    input  logic [REG_W-1:0] dec_rs2,
    input  logic [REG_W-1:0] dec_rd,
    input  logic             dec_wr,
    input  logic             dec_ld,
    input  logic             br_resolved,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_target,
    output logic [1:0]       ex_sel_a,
    output logic [1:0]       ex_sel_b,
    output logic             dec_wb_fwd_a,
    output logic             dec_wb_fwd_b,
    output logic             pc_hold,
    output logic             fd_hold,
    output logic             de_bubble,
    output logic             fd_flush,
    output logic             pc_redirect,
    output logic [PC_W-1:0]  redirect_pc
);

    logic [NUM_OPND-1:0][REG_W-1:0] dec_rs, ex_rs;
    logic [REG_W-1:0]               ex_rd, mem_rd, wb_rd;
    logic                           ex_wr, ex_ld, mem_wr, mem_ld, wb_wr;
    logic                           stall, kill;
    logic [NUM_OPND-1:0][1:0]       ex_src;
    logic [NUM_OPND-1:0]            dec_fwd;

    assign dec_rs[0] = dec_rs1;
    assign dec_rs[1] = dec_rs2;

    hzc_stage_regs #(.REG_W(REG_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .bubble (de_bubble),
        .dec_rs (dec_rs),
        .dec_rd (dec_rd),
        .dec_wr (dec_wr),
        .dec_ld (dec_ld),
        .ex_rs  (ex_rs),
        .ex_rd  (ex_rd),
        .ex_wr  (ex_wr),
        .ex_ld  (ex_ld),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .mem_ld (mem_ld),
        .wb_rd  (wb_rd),
        .wb_wr  (wb_wr)
    );

    hzc_interlock #(.REG_W(REG_W), .PC_W(PC_W)) u_lock (
        .dec_rs      (dec_rs),
        .ex_rd       (ex_rd),
        .ex_wr       (ex_wr),
        .ex_ld       (ex_ld),
        .br_resolved (br_resolved),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .stall       (stall),
        .kill        (kill),
        .target      (redirect_pc)
    );

    hzc_bypass #(.REG_W(REG_W)) u_byp (
        .ex_rs   (ex_rs),
        .dec_rs  (dec_rs),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .mem_ld  (mem_ld),
        .wb_rd   (wb_rd),
        .wb_wr   (wb_wr),
        .kill    (kill),
        .ex_src  (ex_src),
        .dec_fwd (dec_fwd)
    );

    assign ex_sel_a     = ex_src[0];
    assign ex_sel_b     = ex_src[1];
    assign dec_wb_fwd_a = dec_fwd[0];
    assign dec_wb_fwd_b = dec_fwd[1];
    assign pc_hold      = stall;
    assign fd_hold      = stall;
    assign de_bubble    = stall || kill;
    assign fd_flush     = kill;
    assign pc_redirect  = kill;

endmodule

// File: rtl/hzc_checker.sv
module hzc_checker
    import hzc_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] dec_rs1,
    input logic [REG_W-1:0] dec_rs2,
    input logic [REG_W-1:0] dec_rd,
    input logic             dec_wr,
    input logic             dec_ld,
    input logic [1:0]       ex_sel_a,
    input logic             dec_wb_fwd_a,
    input logic             dec_wb_fwd_b,
    input logic             pc_hold,
    input logic             de_bubble,
    input logic             fd_flush,
    input logic             pc_redirect,
    input logic [PC_W-1:0]  br_target,
    input logic [PC_W-1:0]  redirect_pc
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: back-to-back ALU producer/consumer reaches the operand via memory stage
    a_r2_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(de_bubble, 2) && !$past(de_bubble)
         && $past(dec_wr && !dec_ld && dec_rd != '0, 2)
         && $past(dec_rs1) == $past(dec_rd, 2))
        |-> ex_sel_a == SRC_MEM);

    // R6: the interlock never lasts two cycles in a row
    a_r6_one_cycle_stall: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> !pc_hold);

    // R8: a flush wins over the interlock
    a_r8_flush_wins: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> (!pc_hold && fd_flush && de_bubble));

    // R7: discarded decode instruction never appears as a memory-stage source
    a_r7_discard: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |=> ##1 (ex_sel_a != SRC_MEM));

    // R7: redirect address follows the resolved target
    a_r7_target: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> redirect_pc == br_target);

    // R5: index zero is never bypassed into decode
    a_r5_zero_idx: assert property (@(posedge clk) disable iff (rst)
        (dec_wb_fwd_a |-> dec_rs1 != '0) and (dec_wb_fwd_b |-> dec_rs2 != '0));

    // R9: decode bypass is off for a discarded instruction
    a_r9_dec_kill: assert property (@(posedge clk) disable iff (rst)
        pc_redirect |-> (!dec_wb_fwd_a && !dec_wb_fwd_b));

endmodule

bind hzc_top hzc_checker #(.REG_W(REG_W), .PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dec_rs1      (dec_rs1),
    .dec_rs2      (dec_rs2),
    .dec_rd       (dec_rd),
    .dec_wr       (dec_wr),
    .dec_ld       (dec_ld),
    .ex_sel_a     (ex_sel_a),
    .dec_wb_fwd_a (dec_wb_fwd_a),
    .dec_wb_fwd_b (dec_wb_fwd_b),
    .pc_hold      (pc_hold),
    .de_bubble    (de_bubble),
    .fd_flush     (fd_flush),
    .pc_redirect  (pc_redirect),
    .br_target    (br_target),
    .redirect_pc  (redirect_pc)
);

// File: tb/hzc_top_test.sv
module hzc_top_test;

    localparam int RW = 3;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
    logic          dec_wr = 1'b0, dec_ld = 1'b0;
    logic          br_resolved = 1'b0, br_taken = 1'b0;
    logic [PW-1:0] br_target = '0;
    logic [1:0]    ex_sel_a, ex_sel_b;
    logic          dec_wb_fwd_a, dec_wb_fwd_b;
    logic          pc_hold, fd_hold, de_bubble, fd_flush, pc_redirect;
    logic [PW-1:0] redirect_pc;

    int checks = 0;
    int fails  = 0;
    int stall_cycles = 0;
    int stall_expect = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hzc_top #(.REG_W(RW), .PC_W(PW)) uut (
        .clk(clk), .rst(rst),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_rd(dec_rd),
        .dec_wr(dec_wr), .dec_ld(dec_ld),
        .br_resolved(br_resolved), .br_taken(br_taken), .br_target(br_target),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .dec_wb_fwd_a(dec_wb_fwd_a), .dec_wb_fwd_b(dec_wb_fwd_b),
        .pc_hold(pc_hold), .fd_hold(fd_hold), .de_bubble(de_bubble),
        .fd_flush(fd_flush), .pc_redirect(pc_redirect), .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int rs1, input int rs2, input int rd, input bit wr, input bit ld);
        dec_rs1 = RW'(rs1); dec_rs2 = RW'(rs2); dec_rd = RW'(rd);
        dec_wr = wr; dec_ld = ld;
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) next();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", ex_sel_a, 0);
        check("R1", ex_sel_b, 0);
        check("R1", {pc_hold, fd_hold, de_bubble, fd_flush, pc_redirect}, 0);
        check("R1", {dec_wb_fwd_a, dec_wb_fwd_b}, 0);
        next();

        // Sweep: producer two ahead (A), one ahead (B), consumer C
        for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++)
        for (int w = 0; w < 4; w++)
        for (int s = 0; s < 8; s++) begin
            bit wa, wb_, mh, wh;
            int ea, eb;
            string tag;
            wa = w[0]; wb_ = w[1];
            put(0, 0, x, wa, 0); next();
            put(0, 0, y, wb_, 0); next();
            put(s, 7 - s, 0, 0, 0); next();
            put(0, 0, 0, 0, 0); #1;
            mh = wb_ && y != 0 && y == s;
            wh = wa && x != 0 && x == s;
            ea = mh ? 1 : (wh ? 2 : 0);
            mh = wb_ && y != 0 && y == 7 - s;
            wh = wa && x != 0 && x == 7 - s;
            eb = mh ? 1 : (wh ? 2 : 0);
            if (s == 0)           tag = "R5";
            else if (!wa || !wb_) tag = "R10";
            else if (ea == 1 && x == s) tag = "R4";
            else if (ea == 1)     tag = "R2";
            else if (ea == 2)     tag = "R3";
            else                  tag = "R10";
            check(tag, ex_sel_a, ea);
            check("R2", ex_sel_b, eb);
        end

        // Load-use sweep
        for (int x = 0; x < 8; x++)
        for (int s = 0; s < 8; s++) begin
            bit dep;
            dep = (x != 0) && (x == s);
            if (dep) stall_expect++;
            put(0, 0, x, 1, 1); next();
            put(s, 0, 6, 1, 0); #1;
            check(dep ? "R6" : "R5", pc_hold, dep);
            check("R6", fd_hold, dep);
            check("R6", de_bubble, dep);
            if (pc_hold) stall_cycles++;
            if (dep) begin
                next(); #1;
                check("R6", pc_hold, 0);
                if (pc_hold) stall_cycles++;
            end
            next();
            put(0, 0, 0, 0, 0); #1;
            check(dep ? "R6" : "R5", ex_sel_a, dep ? 2 : 0);
            next();
        end
        check("R6", stall_cycles, stall_expect);

        // Decode-stage bypass sweep
        for (int x = 0; x < 8; x++)
        for (int s = 0; s < 8; s++)
        for (int w = 0; w < 2; w++) begin
            put(0, 0, x, w[0], 0); next();
            put(0, 0, 0, 0, 0); next();
            next();
            put(s, x, 0, 0, 0); #1;
            check(s == 0 ? "R5" : "R9", dec_wb_fwd_a, (w == 1 && x != 0 && x == s) ? 1 : 0);
            check("R9", dec_wb_fwd_b, (w == 1 && x != 0) ? 1 : 0);
            next();
        end

        // Branch cases layered on a pending load-use dependency
        for (int t = 0; t < 2; t++)
        for (int k = 0; k < 4; k++) begin
            int tgt;
            tgt = 16'h1000 + k * 16'h0444;
            put(0, 0, 3, 1, 1); next();
            put(3, 0, 5, 1, 0);
            br_resolved = 1'b1; br_taken = t[0]; br_target = PW'(tgt);
            #1;
            if (t == 1) begin
                check("R7", pc_redirect, 1);
                check("R7", redirect_pc, tgt);
                check("R7", fd_flush, 1);
                check("R7", de_bubble, 1);
                check("R8", pc_hold, 0);
                check("R8", fd_hold, 0);
            end else begin
                check("R11", pc_redirect, 0);
                check("R11", fd_flush, 0);
                check("R6", pc_hold, 1);
            end
            next();
            br_resolved = 1'b0; br_taken = 1'b0;
            if (t == 1) begin
                put(5, 3, 0, 0, 0); next();
                put(0, 0, 0, 0, 0); #1;
                check("R7", ex_sel_a, 0);
                check("R3", ex_sel_b, 2);
                next();
            end else begin
                next();
                put(0, 0, 0, 0, 0); #1;
                check("R11", ex_sel_a, 2);
                next();
            end
        end

        // Taken branch while writeback matches decode: decode bypass suppressed
        put(0, 0, 4, 1, 0); next();
        put(0, 0, 0, 0, 0); next();
        next();
        put(4, 4, 0, 0, 0);
        br_resolved = 1'b1; br_taken = 1'b1; #1;
        check("R9", {dec_wb_fwd_a, dec_wb_fwd_b}, 0);
        next();
        br_resolved = 1'b0; br_taken = 1'b0;
        put(0, 0, 0, 0, 0);
        next();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule